// File: doc/BRIEF.md
# Impedance Calibration Update Scheduler

This block decides when an on-die driver and termination calibration engine may load a fresh impedance code. A successive-approximation loop runs continuously against a one-bit comparator. Each finished search is parked in a shadow register. The shadow is copied into the live drive code only in a safe slot. A slot is a REFRESH command, or a NOP cycle while no read burst is in flight, so the swap never disturbs ongoing traffic.

The block also decodes the command stream to track read bursts. It times a power-up window, counted in clock cycles from the clock frequency parameter, after which it reports that the impedance is optimal. Commands are accepted before that point, but the status stays low.

The driver code stands for one sixth of the external reference resistor (120 to 360 ohms, so 20 to 60 ohm drivers). Two termination codes are derived from it. The address/command termination is the full reference value or half of it. The DQ termination is half or a quarter of the reference value. Each choice comes from a pin sampled once, just after reset.

Top module: `zq_update_sched`

## Requirements
- R1: Command encoding on `cmd` is 0 NOP, 1 READ, 2 WRITE, 3 REFRESH, 4 to 7 other commands. `upd_slot` is high in any cycle whose command is REFRESH. It is high on NOP only while `rd_busy` is low, and it is low for every other command.
- R2: A READ sampled at a clock edge raises `rd_busy` for the next RD_LAT+BURST_LEN cycles. A READ issued while busy reloads that full window.
- R3: The search tries one bit per cycle, MSB first, starting from code 100000. A trial bit is kept when `cmp_hi` is 1, which means the trial code is at or below the target. With a steady monotone comparator and steady free slots, `drv_code` settles to the target code within 20 cycles.
- R4: `drv_code` changes only at a clock edge where `upd_slot` was high. It then takes the most recently completed search result. It holds its value through reads and through non-slot commands.
- R5: `cal_done` is low for the first CLK_MHZ*20 clock edges after reset release. It is high from that edge on and never falls again.
- R6: `ca_term` equals 6 times `drv_code` when the latched address/command select is 0 (termination equals the reference), and 3 times `drv_code` when it is 1 (half the reference).
- R7: `dq_term` equals 3 times `drv_code` when the latched DQ select is 1 (half the reference), and floor(3 times `drv_code` / 2) when it is 0 (a quarter of the reference).
- R8: `cfg_ca_half` and `cfg_dq_half` are sampled at the first clock edge after reset release. Later changes on those pins have no effect on `ca_term` or `dq_term`.
- R9: While in reset, `drv_code`, `rd_busy` and `cal_done` are 0, and `sar_trial` is 100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command of this cycle |
| cmp_hi | input | 1 | Comparator: 1 when the trial code is at or below target |
| cfg_ca_half | input | 1 | Address/command termination select (1 = half reference) |
| cfg_dq_half | input | 1 | DQ termination select (1 = half, 0 = quarter reference) |
| sar_trial | output | CODE_W | Trial code driven to the calibration legs |
| drv_code | output | CODE_W | Live driver impedance code |
| ca_term | output | CODE_W+3 | Address/command termination code |
| dq_term | output | CODE_W+3 | DQ termination code |
| upd_slot | output | 1 | This cycle is a safe update point |
| rd_busy | output | 1 | A read burst is in flight |
| cal_done | output | 1 | Power-up calibration window has elapsed |

## Verification
The bench goes after a REFRESH arriving inside a read window. A design that also blocked refreshes would leave the drive code stale until the reads ended. It repeats READs so the busy window must reload. A counter that did not reload would open a NOP slot in the middle of a burst, and the code would change there.

Extreme targets 0 and 63, and neighbours across the mid-code, show up a search that drops its last bit or kept the wrong polarity. The power-up flag is checked on every cycle around its boundary, which exposes an off-by-one edge. Flipping the select pins after reset exposes a latch that keeps following them.

// File: rtl/zq_pkg.sv
package zq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_READ    = 3'd1,
    CMD_WRITE   = 3'd2,
    CMD_REFRESH = 3'd3,
    CMD_ACT     = 3'd4,
    CMD_PRE     = 3'd5,
    CMD_MODE    = 3'd6,
    CMD_DESEL   = 3'd7
  } zq_cmd_e;

  // Reference = 6 * driver code; full reference or half of it.
  function automatic logic [15:0] ca_term_f(input logic [15:0] d, input logic half);
    logic [15:0] x3;
    x3 = d + (d << 1);
    return half ? x3 : (x3 << 1);
  endfunction

  // Half reference = 3 * code, quarter reference = 1.5 * code (floored).
  function automatic logic [15:0] dq_term_f(input logic [15:0] d, input logic half);
    logic [15:0] x3;
    x3 = d + (d << 1);
    return half ? x3 : (x3 >> 1);
  endfunction

endpackage

// File: rtl/zq_cmd_gate.sv
module zq_cmd_gate #(
  parameter int RD_LAT    = 7,
  parameter int BURST_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  output logic       rd_busy,
  output logic       upd_slot
);
  import zq_pkg::*;

  localparam int RD_WIN = RD_LAT + BURST_LEN;
  localparam int RW     = $clog2(RD_WIN + 1);

  logic [RW-1:0] rd_cnt;
  logic          is_nop, is_read, is_ref;

  assign is_nop  = (cmd == CMD_NOP);
  assign is_read = (cmd == CMD_READ);
  assign is_ref  = (cmd == CMD_REFRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_cnt <= '0;
    else if (is_read)
      rd_cnt <= RW'(RD_WIN);
    else if (rd_cnt != '0)
      rd_cnt <= rd_cnt - 1'b1;
  end

  assign rd_busy  = (rd_cnt != '0);
  assign upd_slot = is_ref | (is_nop & ~rd_busy);

endmodule

// File: rtl/zq_sar.sv
module zq_sar #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_hi,
  input  logic              take,
  output logic [CODE_W-1:0] trial,
  output logic [CODE_W-1:0] mask,
  output logic [CODE_W-1:0] shadow,
  output logic              pend,
  output logic              search_done
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] kept;
  logic [CODE_W-1:0] kept_nxt;

  assign trial       = kept | mask;
  assign kept_nxt    = cmp_hi ? trial : kept;
  assign search_done = mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept <= '0;
      mask <= MSB_ONLY;
    end else if (search_done) begin
      kept <= '0;
      mask <= MSB_ONLY;
    end else begin
      kept <= kept_nxt;
      mask <= mask >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      pend   <= 1'b0;
    end else if (search_done) begin
      shadow <= kept_nxt;
      pend   <= 1'b1;
    end else if (take) begin
      pend   <= 1'b0;
    end
  end

endmodule

// File: rtl/zq_pwrup_timer.sv
module zq_pwrup_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int PW = $clog2(CYCLES + 1);
  localparam logic [PW-1:0] LAST = PW'(CYCLES - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/zq_update_sched.sv
module zq_update_sched #(
  parameter int CLK_MHZ   = 100,
  parameter int CODE_W    = 6,
  parameter int RD_LAT    = 7,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic              cmp_hi,
  input  logic              cfg_ca_half,
  input  logic              cfg_dq_half,
  output logic [CODE_W-1:0] sar_trial,
  output logic [CODE_W-1:0] drv_code,
  output logic [CODE_W+2:0] ca_term,
  output logic [CODE_W+2:0] dq_term,
  output logic              upd_slot,
  output logic              rd_busy,
  output logic              cal_done
);
  import zq_pkg::*;

  localparam int PWR_CYC = CLK_MHZ * 20;
  localparam int TERM_W  = CODE_W + 3;

  logic [CODE_W-1:0] sar_mask;
  logic [CODE_W-1:0] shadow;
  logic              pend;
  logic              search_done;
  logic              take;
  logic              sel_taken;
  logic              ca_half_q, dq_half_q;
  logic [15:0]       drv_ext, ca_full, dq_full;

  zq_cmd_gate #(.RD_LAT(RD_LAT), .BURST_LEN(BURST_LEN)) u_gate (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .rd_busy(rd_busy), .upd_slot(upd_slot)
  );

  zq_sar #(.CODE_W(CODE_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .take(take),
    .trial(sar_trial), .mask(sar_mask), .shadow(shadow),
    .pend(pend), .search_done(search_done)
  );

  zq_pwrup_timer #(.CYCLES(PWR_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .done(cal_done)
  );

  assign take = upd_slot & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    drv_code <= '0;
    else if (take) drv_code <= shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_taken <= 1'b0;
      ca_half_q <= 1'b0;
      dq_half_q <= 1'b0;
    end else if (!sel_taken) begin
      sel_taken <= 1'b1;
      ca_half_q <= cfg_ca_half;
      dq_half_q <= cfg_dq_half;
    end
  end

  assign drv_ext = {{(16-CODE_W){1'b0}}, drv_code};
  assign ca_full = ca_term_f(drv_ext, ca_half_q);
  assign dq_full = dq_term_f(drv_ext, dq_half_q);
  assign ca_term = ca_full[TERM_W-1:0];
  assign dq_term = dq_full[TERM_W-1:0];

endmodule

// File: rtl/zq_update_sched_chk.sv
module zq_update_sched_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic              upd_slot,
  input logic              rd_busy,
  input logic              cal_done,
  input logic [CODE_W-1:0] drv_code,
  input logic [CODE_W-1:0] sar_mask,
  input logic              take,
  input logic              pend,
  input logic              sel_taken,
  input logic              cfg_ca_half,
  input logic              ca_half_q
);
  import zq_pkg::*;

  // R1: a refresh is always a slot
  a_r1_refresh_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REFRESH) |-> upd_slot);

  // R1: a NOP inside a read window is not a slot
  a_r1_busy_nop_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP && rd_busy) |-> !upd_slot);

  // R2: a read opens the busy window
  a_r2_read_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ) |=> rd_busy);

  // R3: exactly one trial bit is under test
  a_r3_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sar_mask));

  // R4: the live code moves only after a slot
  a_r4_change_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_code) |-> $past(upd_slot));

  // R4: a swap needs a parked result
  a_r4_take_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend);

  // R5: the optimal flag never falls
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done);

  // R8: the latched select is frozen once taken
  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    sel_taken |=> $stable(ca_half_q));

  // R8: the select is captured from the pin at the first edge
  a_r8_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_taken |=> (ca_half_q == $past(cfg_ca_half)));

endmodule

bind zq_update_sched zq_update_sched_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .upd_slot(upd_slot),
  .rd_busy(rd_busy), .cal_done(cal_done), .drv_code(drv_code),
  .sar_mask(sar_mask), .take(take), .pend(pend), .sel_taken(sel_taken),
  .cfg_ca_half(cfg_ca_half), .ca_half_q(ca_half_q)
);

// File: tb/zq_update_sched_tb.sv
`timescale 1ns/1ps
module zq_update_sched_tb;

  localparam int CLK_MHZ = 100;
  localparam int CODE_W  = 6;
  localparam int RD_WIN  = 15;
  localparam int PWR     = CLK_MHZ * 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [2:0]        cmd;
  logic              cmp_hi;
  logic              cfg_ca_half, cfg_dq_half;
  logic [CODE_W-1:0] sar_trial, drv_code;
  logic [CODE_W+2:0] ca_term, dq_term;
  logic              upd_slot, rd_busy, cal_done;

  logic [CODE_W-1:0] target;
  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int mcnt   = 0;
  logic mca, mdq;
  bit finished = 0;

  always #5 clk = ~clk;

  zq_update_sched #(.CLK_MHZ(CLK_MHZ), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmp_hi(cmp_hi),
    .cfg_ca_half(cfg_ca_half), .cfg_dq_half(cfg_dq_half),
    .sar_trial(sar_trial), .drv_code(drv_code), .ca_term(ca_term),
    .dq_term(dq_term), .upd_slot(upd_slot), .rd_busy(rd_busy),
    .cal_done(cal_done)
  );

  // comparator model: trial at or below target reads high
  always_comb cmp_hi = (sar_trial <= target);

  function automatic int exp_ca(int d, logic half);
    return half ? 3 * d : 6 * d;
  endfunction

  function automatic int exp_dq(int d, logic half);
    return half ? 3 * d : (3 * d) / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic [2:0] c);
    logic exp_slot;
    logic [CODE_W-1:0] old;
    cmd = c;
    #1;
    exp_slot = (c == 3'd3) || (c == 3'd0 && mcnt == 0);
    chk(upd_slot == exp_slot, "R1 slot", upd_slot, exp_slot);
    chk(rd_busy == (mcnt != 0), "R2 busy", rd_busy, mcnt != 0);
    old = drv_code;
    @(posedge clk);
    cyc++;
    if (c == 3'd1) mcnt = RD_WIN;
    else if (mcnt > 0) mcnt--;
    @(negedge clk);
    if (!exp_slot) chk(drv_code == old, "R4 hold outside slot", drv_code, old);
    chk(cal_done == (cyc >= PWR), "R5 cal_done", cal_done, cyc >= PWR);
    chk(int'(ca_term) == exp_ca(drv_code, mca), "R6/R8 ca_term", ca_term, exp_ca(drv_code, mca));
    chk(int'(dq_term) == exp_dq(drv_code, mdq), "R7/R8 dq_term", dq_term, exp_dq(drv_code, mdq));
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CODE_W-1:0] dirs [6];
    logic [2:0] rc;
    int r;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cmd = 3'd0; target = 6'd37;
    cfg_ca_half = 1'b1; cfg_dq_half = 1'b0;
    mca = 1'b1; mdq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(drv_code == 0, "R9 drv_code", drv_code, 0);
    chk(rd_busy == 0, "R9 rd_busy", rd_busy, 0);
    chk(cal_done == 0, "R9 cal_done", cal_done, 0);
    chk(sar_trial == 6'b100000, "R9 sar_trial", sar_trial, 32);
    rst_n = 1'b1;
    step(3'd0);
    // R8: flip the selects after they were taken
    cfg_ca_half = 1'b0; cfg_dq_half = 1'b1;
    for (int i = 0; i < 20; i++) step(3'd0);
    chk(drv_code == 37, "R3 first settle", drv_code, 37);

    // random traffic across the power-up boundary
    for (int i = 0; i < 2600; i++) begin
      r = int'($urandom % 16);
      if (r < 7)       rc = 3'd0;
      else if (r < 10) rc = 3'd1;
      else if (r < 11) rc = 3'd2;
      else if (r < 13) rc = 3'd3;
      else             rc = 3'(4 + ($urandom % 4));
      if (($urandom % 32) == 0) target = CODE_W'($urandom);
      if (($urandom % 50) == 0) begin cfg_ca_half = ~cfg_ca_half; cfg_dq_half = ~cfg_dq_half; end
      step(rc);
    end

    // R3: directed search targets
    dirs[0] = 6'd0; dirs[1] = 6'd63; dirs[2] = 6'd1;
    dirs[3] = 6'd32; dirs[4] = 6'd31; dirs[5] = 6'd42;
    for (int k = 0; k < 6; k++) begin
      target = dirs[k];
      for (int i = 0; i < 20; i++) step(3'd0);
      chk(drv_code == dirs[k], "R3 settle", drv_code, dirs[k]);
    end

    // R4: reads hold the code, refresh inside the window updates it
    target = 6'd63;
    for (int i = 0; i < 20; i++) step(3'd0);
    target = 6'd10;
    for (int i = 0; i < 40; i++) step((i % 8 == 0) ? 3'd1 : 3'd0);
    chk(drv_code == 63, "R4 held through reloaded reads", drv_code, 63);
    chk(rd_busy == 1, "R2 reloaded window", rd_busy, 1);
    step(3'd3);
    chk(drv_code == 10, "R4 refresh in read window", drv_code, 10);

    // R1: writes are never slots
    target = 6'd20;
    for (int i = 0; i < 30; i++) step(3'd2);
    chk(drv_code == 10, "R1 writes give no slot", drv_code, 10);
    step(3'd0);
    chk(drv_code == 20, "R1 NOP slot after reads", drv_code, 20);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule